// File: doc/BRIEF.md
# Shared Control Register Bank with Per-Bit Security Ownership

This block holds a small bank of system-control registers that secure and non-secure software share. Each register has a companion ownership mask, and each mask bit marks a bit, or a group of bits, as secure. A secure access may read and write everything. A non-secure write merges into the register and changes only the bits it owns, so the two worlds can each keep their own fields in one word without a read-modify-write race. The mask words can be changed only by a secure access. The register outputs and the expanded masks are driven straight to the logic being controlled.

Some registers are fine-grained, with one mask bit per data bit, for settings such as per-pin port ownership. The others are coarse, with one mask bit per group of `GRP_W` data bits. This suits a multi-channel peripheral: a channel's whole field becomes secure or non-secure together.

Requests arrive on a valid/ready channel, and every accepted request returns exactly one response on a second valid/ready channel. A response that has not been taken holds the request channel off. `req_ready` is high whenever no response is pending, or when the pending one is being taken in the same cycle. A held response keeps its contents stable until it is taken.

Top module: `sec_shared_regs`

## Requirements
- R1: After reset every data register is zero, every mask word is all ones over its implemented bits (everything secure), `rsp_valid` is low and `req_ready` is high.
- R2: A secure write to a data register (address MSB = 0, low bits = register index) replaces all of its bits.
- R3: A non-secure write to a data register yields (old & mask) | (wdata & ~mask), where mask is the expanded mask. Secure bits never change on a non-secure access.
- R4: A secure read of a data register returns its full value.
- R5: A non-secure read of a data register returns its value with every secure bit position forced to zero.
- R6: A secure write to a mask word (address MSB = 1, low bits = register index) stores the written value. On a fine register (index < `NUM_BIT_REGS`), mask bit b guards data bit b.
- R7: On a coarse register (index ≥ `NUM_BIT_REGS`), mask bit g guards data bits [g*GRP_W +: GRP_W]. Only the low DATA_W/GRP_W bits of the mask word exist; higher written bits are dropped and read back as zero. A mask read by either world returns the stored word.
- R8: A non-secure write to a mask word leaves every mask unchanged and answers with `rsp_err` = 1. Every other response has `rsp_err` = 0, and a write response carries `rsp_rdata` = 0.
- R9: `req_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and no request is accepted.
- R10: A request accepted at a clock edge has its response valid, and its write effect visible on `reg_q`/`sec_mask`, right after that edge. Read data reflects the state before the edge. Without an accepted request, no register or mask changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Security tag of the request, 1 = secure |
| req_addr | input | ADDR_W | MSB selects mask (1) or data (0); low bits pick the register |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | DATA_W | Read data, zero for writes |
| rsp_err | output | 1 | Non-secure attempt to change a mask |
| reg_q | output | NUM_REGS*DATA_W | All data registers, register i at [i*DATA_W +: DATA_W] |
| sec_mask | output | NUM_REGS*DATA_W | Expanded ownership masks, 1 = secure bit |

## Verification
Every result belongs to the edge that accepts the request. The register and mask outputs and the response all change at that edge, and the read data reflects the state before it. The bench drives inputs on the falling edge and updates a behavioural model at the rising edge that accepts a request. At the next falling edge it compares the response and, on every cycle, the whole register and mask state. During back-pressure it samples at falling edges while the response is held, to check that the response stays put and that a stalled request changes nothing until the response is taken.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [1:0] {
    ACC_DATA_RD = 2'd0,
    ACC_DATA_WR = 2'd1,
    ACC_MASK_RD = 2'd2,
    ACC_MASK_WR = 2'd3
  } acc_e;

  typedef struct packed {
    logic fire;
    logic secure;
    acc_e kind;
  } acc_t;

  function automatic acc_e classify(input logic is_mask, input logic is_write);
    return acc_e'({is_mask, is_write});
  endfunction

endpackage

// File: rtl/ssr_bus_port.sv
module ssr_bus_port
  import ssr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_ready,
  input  logic [DATA_W-1:0] rd_value,
  output acc_t              acc,
  output logic [IDX_W-1:0]  idx,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);

  logic fire;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  assign acc.fire   = fire;
  assign acc.secure = req_secure;
  assign acc.kind   = classify(req_addr[ADDR_W-1], req_write);
  assign idx        = req_addr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_err   <= (acc.kind == ACC_MASK_WR) && !req_secure;
      rsp_rdata <= req_write ? '0 : rd_value;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/ssr_mask_slot.sv
module ssr_mask_slot #(
  parameter int DATA_W = 16,
  parameter int GRP_W  = 1,
  localparam int MW    = DATA_W / GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_full,
  output logic [DATA_W-1:0] mask_word
);

  logic [MW-1:0] own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     own <= '1;
    else if (wr_en) own <= wdata[MW-1:0];
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_expand
    assign mask_full[b] = own[b / GRP_W];
  end

  if (MW == DATA_W) begin : g_full_word
    assign mask_word = own;
  end else begin : g_packed_word
    assign mask_word = {{(DATA_W - MW){1'b0}}, own};
  end

endmodule

// File: rtl/ssr_data_slot.sv
module ssr_data_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              secure,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] mask_full,
  output logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] q_open
);

  logic [DATA_W-1:0] merged;

  assign merged = secure ? wdata : ((q & mask_full) | (wdata & ~mask_full));
  assign q_open = q & ~mask_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= merged;
  end

endmodule

// File: rtl/sec_shared_regs.sv
module sec_shared_regs
  import ssr_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int NUM_REGS     = 4,
  parameter int NUM_BIT_REGS = 2,
  parameter int GRP_W        = 4,
  localparam int IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int ADDR_W      = IDX_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic                       req_secure,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic                       rsp_err,
  output logic [NUM_REGS*DATA_W-1:0] reg_q,
  output logic [NUM_REGS*DATA_W-1:0] sec_mask
);

  acc_t              acc;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] rd_value;

  logic [DATA_W-1:0] q_arr     [NUM_REGS];
  logic [DATA_W-1:0] open_arr  [NUM_REGS];
  logic [DATA_W-1:0] mfull_arr [NUM_REGS];
  logic [DATA_W-1:0] mword_arr [NUM_REGS];

  ssr_bus_port #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_secure(req_secure),
    .req_addr  (req_addr),
    .rsp_ready (rsp_ready),
    .rd_value  (rd_value),
    .acc       (acc),
    .idx       (idx),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    localparam int SLOT_GRP = (i < NUM_BIT_REGS) ? 1 : GRP_W;
    logic hit, data_we, mask_we;

    assign hit     = acc.fire && (idx == IDX_W'(i));
    assign data_we = hit && (acc.kind == ACC_DATA_WR);
    assign mask_we = hit && (acc.kind == ACC_MASK_WR) && acc.secure;

    ssr_mask_slot #(.DATA_W(DATA_W), .GRP_W(SLOT_GRP)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (mask_we),
      .wdata    (req_wdata),
      .mask_full(mfull_arr[i]),
      .mask_word(mword_arr[i])
    );

    ssr_data_slot #(.DATA_W(DATA_W)) u_data (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (data_we),
      .secure   (acc.secure),
      .wdata    (req_wdata),
      .mask_full(mfull_arr[i]),
      .q        (q_arr[i]),
      .q_open   (open_arr[i])
    );

    assign reg_q[i*DATA_W +: DATA_W]    = q_arr[i];
    assign sec_mask[i*DATA_W +: DATA_W] = mfull_arr[i];
  end

  always_comb begin
    unique case (acc.kind)
      ACC_DATA_RD: rd_value = acc.secure ? q_arr[idx] : open_arr[idx];
      ACC_MASK_RD: rd_value = mword_arr[idx];
      default:     rd_value = '0;
    endcase
  end

endmodule

// File: rtl/ssr_chk.sv
module ssr_chk #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 3,
  parameter int IDX_W    = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic                       req_write,
  input logic                       req_secure,
  input logic [ADDR_W-1:0]          req_addr,
  input logic                       rsp_valid,
  input logic                       rsp_ready,
  input logic [DATA_W-1:0]          rsp_rdata,
  input logic                       rsp_err,
  input logic [NUM_REGS*DATA_W-1:0] reg_q,
  input logic [NUM_REGS*DATA_W-1:0] sec_mask
);

  logic             fire;
  logic [IDX_W-1:0] last_idx;

  assign fire = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_idx <= '0;
    else        last_idx <= req_addr[IDX_W-1:0];
  end

  p_ns_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_secure) |=> (((reg_q ^ $past(reg_q)) & $past(sec_mask)) == '0));

  p_ns_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_secure && !req_write && !req_addr[ADDR_W-1])
      |=> ((rsp_rdata & sec_mask[int'(last_idx)*DATA_W +: DATA_W]) == '0));

  p_mask_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_secure && req_write && req_addr[ADDR_W-1])
      |=> ($stable(sec_mask) && rsp_err));

  p_sec_noerr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_secure) |=> !rsp_err);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  p_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(reg_q) && $stable(sec_mask)));

endmodule

bind sec_shared_regs ssr_chk #(
  .DATA_W  (DATA_W),
  .NUM_REGS(NUM_REGS),
  .ADDR_W  (ADDR_W),
  .IDX_W   (IDX_W)
) u_chk (.*);

// File: tb/tb_sec_shared_regs.sv
`timescale 1ns/1ps
module tb_sec_shared_regs;

  localparam int DATA_W = 16;
  localparam int NREG   = 4;
  localparam int NBIT   = 2;
  localparam int GRP_W  = 4;
  localparam int IDX_W  = 2;
  localparam int ADDR_W = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_secure = 0, rsp_ready = 1;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [DATA_W-1:0] rsp_rdata;
  logic [NREG*DATA_W-1:0] reg_q, sec_mask;

  always #10 clk = ~clk;

  sec_shared_regs dut (.*);

  int total = 0, bad = 0;
  bit cmp_on = 0, done = 0;
  string cur_tag = "R1";
  logic [DATA_W-1:0] mq [NREG];
  logic [DATA_W-1:0] mm [NREG];

  function automatic int mwidth(int i);
    return (i < NBIT) ? DATA_W : DATA_W / GRP_W;
  endfunction

  function automatic logic [DATA_W-1:0] wmask(int i);
    logic [DATA_W-1:0] r = '0;
    for (int b = 0; b < mwidth(i); b++) r[b] = 1'b1;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] fullm(int i);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < DATA_W; b++) r[b] = (i < NBIT) ? mm[i][b] : mm[i][b / GRP_W];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    for (int i = 0; i < NREG; i++) begin
      chk(reg_q[i*DATA_W +: DATA_W] === mq[i], {cur_tag, " data state"}, 64'(reg_q[i*DATA_W +: DATA_W]), 64'(mq[i]));
      chk(sec_mask[i*DATA_W +: DATA_W] === fullm(i), {cur_tag, " mask state"}, 64'(sec_mask[i*DATA_W +: DATA_W]), 64'(fullm(i)));
    end
  end

  task automatic acc(input logic wr, input logic sec, input logic [ADDR_W-1:0] a,
                     input logic [DATA_W-1:0] d, input string tag);
    logic [DATA_W-1:0] erd;
    logic eerr;
    int i;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_tag = tag;
    req_valid = 1; req_write = wr; req_secure = sec; req_addr = a; req_wdata = d;
    i = int'(a[IDX_W-1:0]);
    eerr = wr && a[ADDR_W-1] && !sec;
    if (wr) erd = '0;
    else if (a[ADDR_W-1]) erd = mm[i];
    else erd = sec ? mq[i] : (mq[i] & ~fullm(i));
    @(posedge clk);
    if (wr && !a[ADDR_W-1]) mq[i] = sec ? d : ((mq[i] & fullm(i)) | (d & ~fullm(i)));
    if (wr && a[ADDR_W-1] && sec) mm[i] = d & wmask(i);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1, {tag, " R10 response due"}, 64'(rsp_valid), 64'd1);
    chk(rsp_rdata === erd, {tag, " rdata"}, 64'(rsp_rdata), 64'(erd));
    chk(rsp_err === eerr, {tag, " R8 err flag"}, 64'(rsp_err), 64'(eerr));
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin mq[i] = '0; mm[i] = wmask(i); end
    repeat (3) @(negedge clk);
    chk(reg_q === '0, "R1 regs zero", 64'(reg_q), 0);
    chk(rsp_valid === 1'b0, "R1 no response", 64'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready", 64'(req_ready), 1);
    cmp_on = 1;

    acc(1, 0, 3'd0, 16'hFFFF, "R3 all-secure");
    acc(1, 0, 3'd4, 16'h00FF, "R8 ns mask write");
    acc(1, 1, 3'd4, 16'h0F0F, "R6 mask set");
    acc(1, 0, 3'd0, 16'hFFFF, "R3 merge");
    chk(reg_q[15:0] === 16'hF0F0, "R3 merged value", 64'(reg_q[15:0]), 64'hF0F0);
    acc(1, 1, 3'd0, 16'h1234, "R2 secure write");
    acc(0, 0, 3'd0, '0, "R5 ns read");
    acc(0, 1, 3'd0, '0, "R4 secure read");
    acc(1, 1, 3'd6, 16'hFFF5, "R7 group mask");
    acc(0, 0, 3'd6, '0, "R7 mask readback");
    acc(1, 0, 3'd2, 16'hAAAA, "R7 group merge");
    chk(reg_q[47:32] === 16'hA0A0, "R7 group value", 64'(reg_q[47:32]), 64'hA0A0);
    acc(1, 0, 3'd5, 16'h0000, "R8 ns mask write 2");

    // R9 back-pressure
    @(negedge clk); rsp_ready = 0;
    acc(0, 1, 3'd2, '0, "R9 held read");
    for (int k = 0; k < 3; k++) begin
      req_valid = 1; req_write = 1; req_secure = 1; req_addr = 3'd1; req_wdata = 16'hBEEF;
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_rdata === 16'hA0A0, "R9 response held", 64'(rsp_rdata), 64'hA0A0);
      chk(req_ready === 1'b0, "R9 ready low", 64'(req_ready), 0);
    end
    req_valid = 0; rsp_ready = 1;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R9 response taken", 64'(rsp_valid), 0);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] r = $urandom;
      acc(r[0], r[1], r[4:2], r[31:16], "R3 random mix");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule